// File: doc/BRIEF.md
# Dual-Rail Delay-Insensitive Half Adder

This block adds two single-bit operands that each arrive on a pair of rails. It returns a carry pair and a sum pair in the same encoding. A data word is marked by exactly one rail of a pair sitting at its active level. A spacer, meaning no data, is marked by both rails sitting at the inactive level. The design is a clocked model of the asynchronous circuit. Each of the four C-elements is a two-state machine that moves only when both of its inputs agree. That gives the adder its completion behaviour: results appear only after both operands are complete, and they clear only after both operands have cleared.

The parameter `RET_ONE` selects the signalling convention. With `RET_ONE = 0`, the active level is high, the spacer is all zeros, and the output rails OR together the minterm C-elements. With `RET_ONE = 1`, the active level is low and the spacer is all ones. In that case the same C-elements compute maxterms, and the output rails AND them together. Every wire is then the inverse of the wire it would carry in the zero-spacer convention.

A surrounding handshake controller presents operands, waits for a complete result, and then returns the operands to the spacer. Results follow input changes after one clock edge.

Top module: `dims_half_adder`

## Requirements
- R1: While `rst_n` is low, and after reset until both operands carry data, every output rail sits at the spacer level: 0 when RET_ONE=0, 1 when RET_ONE=1.
- R2: Rail encoding. Bit [1] of a pair active means logical 1 and bit [0] active means logical 0. The active level is 1 when RET_ONE=0 and 0 when RET_ONE=1. A pair with no rail active is a spacer.
- R3: When both operands carry data, the carry pair encodes a AND b. It does so one clock edge after the later operand arrives.
- R4: When both operands carry data, the sum pair encodes a XOR b. It does so one clock edge after the later operand arrives.
- R5: While one operand carries data and the other is a spacer, an output that is a spacer stays a spacer.
- R6: While one operand has returned to the spacer and the other still carries data, valid outputs hold their value.
- R7: One clock edge after both operands are spacers, both output pairs are spacers.
- R8: No output pair ever has both rails active.
- R9: For RET_ONE=1, every output wire is the bitwise inverse of the RET_ONE=0 output wire when every input wire is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the C-element state |
| rst_n | input | 1 | Active-low reset; loads the spacer state |
| a_rail | input | 2 | Operand A, [1]=true rail, [0]=false rail |
| b_rail | input | 2 | Operand B, [1]=true rail, [0]=false rail |
| carry_rail | output | 2 | Carry, [1]=true rail, [0]=false rail |
| sum_rail | output | 2 | Sum, [1]=true rail, [0]=false rail |

## Verification
The bench builds two instances side by side, one with RET_ONE=0 and one with RET_ONE=1. The second instance receives the inverted wires of the first. One stimulus stream therefore exercises both the OR-merged minterm logic and the AND-merged maxterm logic, and the bench can compare the two instances wire for wire. Since every operand pair, staggered arrival order and staggered release order reach both instances, the hold and completion behaviour is checked under both spacer levels.

// File: rtl/dims_pkg.sv
package dims_pkg;

    typedef enum logic {
        C_LO = 1'b0,
        C_HI = 1'b1
    } cel_state_t;

    localparam int RAILS    = 2;
    localparam int MINTERMS = RAILS * RAILS;

endpackage

// File: rtl/dims_celem.sv
module dims_celem
    import dims_pkg::*;
#(
    parameter bit RET_ONE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_x,
    input  logic in_y,
    output logic q
);

    localparam cel_state_t IDLE_ST = RET_ONE ? C_HI : C_LO;

    cel_state_t state_q;
    cel_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_LO: if (in_x && in_y)   state_d = C_HI;
            C_HI: if (!in_x && !in_y) state_d = C_LO;
            default: state_d = IDLE_ST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        q = (state_q == C_HI);
    end

    assert_celem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_x != in_y) |=> $stable(q));

endmodule

// File: rtl/dims_merge.sv
module dims_merge #(
    parameter int N       = 2,
    parameter bit RET_ONE = 1'b0
) (
    input  logic [N-1:0] terms,
    output logic         rail
);

    generate
        if (RET_ONE) begin : g_and
            assign rail = &terms;
        end else begin : g_or
            assign rail = |terms;
        end
    endgenerate

endmodule

// File: rtl/dims_half_adder.sv
module dims_half_adder
    import dims_pkg::*;
#(
    parameter bit RET_ONE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] a_rail,
    input  logic [1:0] b_rail,
    output logic [1:0] carry_rail,
    output logic [1:0] sum_rail
);

    localparam logic [1:0] SPACER = RET_ONE ? 2'b11 : 2'b00;

    // term[{i,j}] joins A rail i with B rail j
    logic [MINTERMS-1:0] term;

    genvar gi, gj;
    generate
        for (gi = 0; gi < RAILS; gi++) begin : g_a
            for (gj = 0; gj < RAILS; gj++) begin : g_b
                dims_celem #(.RET_ONE(RET_ONE)) u_cel (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .in_x (a_rail[gi]),
                    .in_y (b_rail[gj]),
                    .q    (term[gi*RAILS+gj])
                );
            end
        end
    endgenerate

    dims_merge #(.N(1), .RET_ONE(RET_ONE)) u_carry_t (
        .terms(term[3]), .rail(carry_rail[1]));
    dims_merge #(.N(3), .RET_ONE(RET_ONE)) u_carry_f (
        .terms(term[2:0]), .rail(carry_rail[0]));
    dims_merge #(.N(2), .RET_ONE(RET_ONE)) u_sum_t (
        .terms({term[2], term[1]}), .rail(sum_rail[1]));
    dims_merge #(.N(2), .RET_ONE(RET_ONE)) u_sum_f (
        .terms({term[3], term[0]}), .rail(sum_rail[0]));

    logic a_sp, b_sp, a_ok, b_ok;
    assign a_sp = (a_rail == SPACER);
    assign b_sp = (b_rail == SPACER);
    assign a_ok = ($countones(a_rail ^ SPACER) == 1);
    assign b_ok = ($countones(b_rail ^ SPACER) == 1);

    assert_spacer_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sp && b_sp) |=> (carry_rail == SPACER && sum_rail == SPACER));

    assert_valid_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ok && b_ok) |=> ($countones(carry_rail ^ SPACER) == 1));

    assert_valid_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ok && b_ok) |=> ($countones(sum_rail ^ SPACER) == 1));

    assert_hold_mixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_sp && b_ok) || (a_ok && b_sp)) |=> ($stable(carry_rail) && $stable(sum_rail)));

    assert_no_double_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(carry_rail ^ SPACER) <= 1 && $countones(sum_rail ^ SPACER) <= 1));

endmodule

// File: tb/dims_half_adder_bench.sv
module dims_half_adder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] az = 2'b00, bz = 2'b00;
    logic [1:0] cz, sz, co, so;
    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dims_half_adder #(.RET_ONE(1'b0)) u_dims_half_adder (
        .clk(clk), .rst_n(rst_n), .a_rail(az), .b_rail(bz),
        .carry_rail(cz), .sum_rail(sz));

    dims_half_adder #(.RET_ONE(1'b1)) u_dims_half_adder_rto (
        .clk(clk), .rst_n(rst_n), .a_rail(~az), .b_rail(~bz),
        .carry_rail(co), .sum_rail(so));

    function automatic logic [1:0] enc(input logic v);
        return v ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    // checks both instances against a zero-spacer expectation (R2, R9)
    task automatic chk_both(input string req, input logic [1:0] ec, input logic [1:0] es);
        chk({req, " carry rz"}, cz, ec);
        chk({req, " sum rz"}, sz, es);
        chk({req, " carry ro R9"}, co, ~ec);
        chk({req, " sum ro R9"}, so, ~es);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic run_op(input logic a, input logic b, input int arr, input int rel);
        logic [1:0] ec, es;
        ec = enc(a & b);
        es = enc(a ^ b);
        if (arr == 0) begin
            az = enc(a); tick(); chk_both("R5 A-first", 2'b00, 2'b00);
            tick();            chk_both("R5 A-first wait", 2'b00, 2'b00);
            bz = enc(b);
        end else if (arr == 1) begin
            bz = enc(b); tick(); chk_both("R5 B-first", 2'b00, 2'b00);
            az = enc(a);
        end else begin
            az = enc(a); bz = enc(b);
        end
        tick();
        chk_both("R3 R4 result", ec, es);
        if (rel == 0) begin
            az = 2'b00; tick(); chk_both("R6 A-released", ec, es);
            tick();            chk_both("R6 A-released wait", ec, es);
            bz = 2'b00;
        end else if (rel == 1) begin
            bz = 2'b00; tick(); chk_both("R6 B-released", ec, es);
            az = 2'b00;
        end else begin
            az = 2'b00; bz = 2'b00;
        end
        tick();
        chk_both("R7 spacer", 2'b00, 2'b00);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        tick();
        chk_both("R1 in reset", 2'b00, 2'b00);
        tick();
        rst_n = 1'b1;
        tick();
        chk_both("R1 after reset", 2'b00, 2'b00);
        // directed: every operand pair in every arrival order
        for (int v = 0; v < 4; v++) begin
            for (int o = 0; o < 3; o++) begin
                run_op(v[1], v[0], o, 2 - o);
            end
        end
        // random mix
        for (int k = 0; k < 200; k++) begin
            run_op(1'($urandom), 1'($urandom), int'($urandom % 3), int'($urandom % 3));
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule